// File: doc/BRIEF.md
# Colour Channel Selection Sequencer

This block decides which colour channel (red, green or blue) a single-path scanner front end works on when it runs in line-by-line colour mode. It drives three 2-bit selects: one for the analog input multiplexer, one for the offset-register multiplexer and one for the gain-register multiplexer. It also drives power-down outputs for the green and blue channels and a force-mono flag.

The selects come from one of three places: a register colour field, a register force field that steers only the input multiplexer, or an internal counter that steps red, green, blue and back to red each time an external line-clock pin is pulsed. The pin is asynchronous. It passes through a two-flop synchroniser and a rising-edge detector, so a pin held high steps the counter only once. With line-by-line mode off, the selects simply follow the register colour field and nothing is powered down.

Top module: `colour_sel_seq`

## Requirements
- R1: After reset, all three selects are 00 (red) and pd_green, pd_blue and mono_force are 0.
- R2: With lbl_en low, all three selects equal the colour field col_sel one clock after it is applied, and pd_green, pd_blue and mono_force are 0.
- R3: With lbl_en high, pd_green, pd_blue and mono_force are 1 from the clock after lbl_en is set.
- R4: With lbl_en high, acyc_en low and frc_en low, all three selects equal col_sel.
- R5: With lbl_en high, acyc_en high and frc_en low, all three selects equal the cycle counter, which steps red, green, blue, red on successive line pulses.
- R6: With lbl_en high, acyc_en low and frc_en high, in_sel equals frc_sel, while ofs_sel and gain_sel equal col_sel.
- R7: With lbl_en high, acyc_en high and frc_en high, in_sel equals frc_sel, while ofs_sel and gain_sel follow the cycle counter.
- R8: Colour codes are 00 red, 01 green, 10 blue; a field value of 11 is treated as red, so no select output ever shows 11.
- R9: A rising edge on line_clk that stays high for any number of clocks steps the counter once. The new select appears on the third rising clock edge after line_clk goes high: two edges for the synchroniser and one for the registered output.
- R10: The cycle counter returns to red on reset and while acyc_en or lbl_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lbl_en | input | 1 | Line-by-line colour mode enable |
| acyc_en | input | 1 | Auto-cycle source enable |
| frc_en | input | 1 | Force field drives the input select |
| col_sel | input | 2 | Register colour field |
| frc_sel | input | 2 | Register force field for the input select |
| line_clk | input | 1 | Asynchronous line-clock pulse pin |
| in_sel | output | 2 | Input multiplexer select |
| ofs_sel | output | 2 | Offset register select |
| gain_sel | output | 2 | Gain register select |
| pd_green | output | 1 | Green channel power-down |
| pd_blue | output | 1 | Blue channel power-down |
| mono_force | output | 1 | Forced mono operation |

## Verification
The hardest case to reach is the split between the input select and the offset and gain selects. In that case a line pulse steps the offset and gain selects while the input select stays on a forced colour. The counter must also wrap correctly from blue back to red. The bench reaches this case by turning on force and auto-cycle together and then issuing a run of pulses, some short and some held high for many clocks. After each pulse it compares all three selects with a counter kept in the bench. It also checks the exact edge at which a change appears, and that the counter clears when auto-cycle is dropped in the middle of a sequence.

// File: rtl/colour_sel_seq.sv
module colour_sel_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lbl_en,
  input  logic       acyc_en,
  input  logic       frc_en,
  input  logic [1:0] col_sel,
  input  logic [1:0] frc_sel,
  input  logic       line_clk,
  output logic [1:0] in_sel,
  output logic [1:0] ofs_sel,
  output logic [1:0] gain_sel,
  output logic       pd_green,
  output logic       pd_blue,
  output logic       mono_force
);
  localparam logic [1:0] RED   = 2'b00;
  localparam logic [1:0] GREEN = 2'b01;
  localparam logic [1:0] BLUE  = 2'b10;

  logic       sync_a, sync_b, sync_d;
  logic       step;
  logic       run;
  logic [1:0] cyc_q, cyc_d;
  logic [1:0] col_n, frc_n;
  logic [1:0] in_d, reg_d;

  function automatic logic [1:0] norm(input logic [1:0] c);
    return (c == 2'b11) ? RED : c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      sync_d <= 1'b0;
    end else begin
      sync_a <= line_clk;
      sync_b <= sync_a;
      sync_d <= sync_b;
    end
  end

  assign step = sync_b & ~sync_d;
  assign run  = lbl_en & acyc_en;

  always_comb begin
    cyc_d = cyc_q;
    if (!run)
      cyc_d = RED;
    else if (step)
      case (cyc_q)
        RED:     cyc_d = GREEN;
        GREEN:   cyc_d = BLUE;
        default: cyc_d = RED;
      endcase
  end

  assign col_n = norm(col_sel);
  assign frc_n = norm(frc_sel);
  assign reg_d = !lbl_en ? col_n : (acyc_en ? cyc_d : col_n);
  assign in_d  = (lbl_en && frc_en) ? frc_n : reg_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q      <= RED;
      in_sel     <= RED;
      ofs_sel    <= RED;
      gain_sel   <= RED;
      pd_green   <= 1'b0;
      pd_blue    <= 1'b0;
      mono_force <= 1'b0;
    end else begin
      cyc_q      <= cyc_d;
      in_sel     <= in_d;
      ofs_sel    <= reg_d;
      gain_sel   <= reg_d;
      pd_green   <= lbl_en;
      pd_blue    <= lbl_en;
      mono_force <= lbl_en;
    end
  end
endmodule

module colour_sel_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lbl_en,
  input logic       acyc_en,
  input logic       frc_en,
  input logic [1:0] col_sel,
  input logic [1:0] frc_sel,
  input logic [1:0] in_sel,
  input logic [1:0] ofs_sel,
  input logic [1:0] gain_sel,
  input logic       pd_green,
  input logic       pd_blue,
  input logic       mono_force
);
  p_pd_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lbl_en |=> (pd_green && pd_blue && mono_force));

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lbl_en |=> (!pd_green && !pd_blue && !mono_force &&
                 in_sel == (($past(col_sel) == 2'b11) ? 2'b00 : $past(col_sel))));

  p_force_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lbl_en && frc_en) |=>
      in_sel == (($past(frc_sel) == 2'b11) ? 2'b00 : $past(frc_sel)));

  p_no_code3_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_sel != 2'b11 && ofs_sel != 2'b11 && gain_sel != 2'b11);

  p_gain_ofs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gain_sel == ofs_sel);

  p_step_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lbl_en && acyc_en) && $past(lbl_en && acyc_en, 2) &&
     ofs_sel != $past(ofs_sel)) |->
      ofs_sel == (($past(ofs_sel) == 2'b10) ? 2'b00 : $past(ofs_sel) + 2'b01));
endmodule

bind colour_sel_seq colour_sel_seq_chk u_chk (.*);

// File: tb/test_colour_sel_seq.sv
module test_colour_sel_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lbl_en = 1'b0, acyc_en = 1'b0, frc_en = 1'b0, line_clk = 1'b0;
  logic [1:0] col_sel = 2'b00, frc_sel = 2'b00;
  logic [1:0] in_sel, ofs_sel, gain_sel;
  logic       pd_green, pd_blue, mono_force;
  int         n_run = 0, n_fail = 0;
  logic [1:0] cnt;

  always #2.5 clk = ~clk;

  colour_sel_seq i_colour_sel_seq (.*);

  function automatic logic [1:0] nrm(input logic [1:0] c);
    return (c == 2'b11) ? 2'b00 : c;
  endfunction

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string req, input logic [1:0] ei, input logic [1:0] er, input logic pd);
    chk(req, in_sel, ei);
    chk(req, ofs_sel, er);
    chk(req, gain_sel, er);
    chk(req, {pd_green, pd_blue}, {pd, pd});
    chk(req, {1'b0, mono_force}, {1'b0, pd});
  endtask

  task automatic pulse(input int hold);
    line_clk = 1'b1;
    repeat (hold) @(negedge clk);
    line_clk = 1'b0;
    repeat (4) @(negedge clk);
    cnt = (cnt == 2'd2) ? 2'd0 : cnt + 2'd1;
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1 reset", 2'd0, 2'd0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after release", 2'd0, 2'd0, 1'b0);

    // Static sweep over all field and mode combinations; no pulses, so the counter is red
    for (int m = 0; m < 8; m++)
      for (int c = 0; c < 4; c++)
        for (int f = 0; f < 4; f++) begin
          logic [1:0] ei, er;
          {lbl_en, acyc_en, frc_en} = m[2:0];
          col_sel = c[1:0];
          frc_sel = f[1:0];
          @(negedge clk);
          if (!lbl_en) begin
            er = nrm(col_sel); ei = er;
            chk_all("R2 R8 mode off", ei, er, 1'b0);
          end else begin
            er = acyc_en ? 2'd0 : nrm(col_sel);
            ei = frc_en ? nrm(frc_sel) : er;
            if (frc_en) chk_all(acyc_en ? "R7 R8 force auto" : "R6 R8 force reg", ei, er, 1'b1);
            else        chk_all(acyc_en ? "R5 auto idle" : "R4 R8 reg", ei, er, 1'b1);
          end
        end

    // R9 latency: the change lands on the third rising edge after the pin rises
    lbl_en = 1'b1; acyc_en = 1'b1; frc_en = 1'b0; col_sel = 2'd2;
    repeat (2) @(negedge clk);
    cnt = 2'd0;
    line_clk = 1'b1;
    @(negedge clk); chk("R9 edge1", ofs_sel, 2'd0);
    @(negedge clk); chk("R9 edge2", ofs_sel, 2'd0);
    @(negedge clk); chk("R9 edge3", ofs_sel, 2'd1);
    // held high for many clocks: no further step
    repeat (20) @(negedge clk);
    chk("R9 held", ofs_sel, 2'd1);
    line_clk = 1'b0;
    repeat (4) @(negedge clk);
    cnt = 2'd1;

    // R5 order red, green, blue, red, all selects together
    for (int k = 0; k < 7; k++) begin
      pulse((k % 3) + 1);
      chk_all("R5 cycle", cnt, cnt, 1'b1);
    end

    // R7 force with auto-cycle: input stays, offset/gain step
    frc_en = 1'b1;
    for (int f = 0; f < 4; f++) begin
      frc_sel = f[1:0];
      for (int k = 0; k < 4; k++) begin
        pulse(k == 2 ? 15 : 1);
        chk_all("R7 split", nrm(frc_sel), cnt, 1'b1);
      end
    end

    // R10 clearing auto-cycle returns the counter to red
    if (cnt == 2'd0) pulse(1);
    acyc_en = 1'b0; col_sel = 2'd1;
    @(negedge clk);
    chk("R6 back to reg", ofs_sel, 2'd1);
    acyc_en = 1'b1;
    @(negedge clk);
    cnt = 2'd0;
    chk_all("R10 acyc clear", nrm(frc_sel), 2'd0, 1'b1);
    pulse(1);
    chk("R10 restart green", ofs_sel, 2'd1);

    // R10 reset returns to red
    pulse(1);
    rst_n = 1'b0;
    @(negedge clk);
    chk_all("R1 R10 reset mid", 2'd0, 2'd0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after reset", ofs_sel, 2'd0);

    // R2 pulses ignored when line-by-line is off
    lbl_en = 1'b0; col_sel = 2'd3;
    repeat (2) @(negedge clk);
    pulse(2);
    chk_all("R2 pulse ignored", 2'd0, 2'd0, 1'b0);
    col_sel = 2'd2;
    @(negedge clk);
    chk_all("R2 follow col", 2'd2, 2'd2, 1'b0);
    lbl_en = 1'b1; frc_en = 1'b0; acyc_en = 1'b0;
    @(negedge clk);
    chk_all("R3 R4 enable", 2'd2, 2'd2, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule